// File: doc/BRIEF.md
# Approximate Compressor-Tree Multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product. It forms every AND partial product of the operands and sorts them into columns by weight. Stage by stage, it cuts each column down until no column holds more than two bits. In the approximate configuration, each group of four equal-weight bits goes through a 4:2 compressor with no carry chain. That compressor is cheaper than an exact one, but it undercounts on two of its sixteen input patterns. Where a column has three bits left over, they go through a full adder, and one or two leftover bits pass straight to the next stage. A logarithmic-depth Kogge-Stone prefix adder then sums the two surviving rows.

A parameter selects an exact configuration, in which every reduction is done with full adders. The same generated tree can then be compared against an exact product. The per-column heights, the number of stages and the wiring are all derived at elaboration time from N. A second parameter selects either a registered output with a synchronous active-high reset, or a purely combinational output.

Top module: `cmptree_mul`

## Requirements
- R1: Partial product (i,j) is a[i] AND b[j] and has weight 2^(i+j); operands are unsigned and the product p is 2N bits wide.
- R2: With APPROX=0, p equals a*b for every operand pair (exhaustively at N=8).
- R3: The 4:2 compressor takes four equal-weight bits x[3:0] and gives sum (weight 1) and carry (weight 2), with 2*carry+sum equal to the number of ones for 14 patterns. For x=4'b1111 it gives carry=1, sum=1. For x=4'b1001 (x[0]=x[3]=1) it gives carry=0, sum=1.
- R4: With APPROX=1, p never exceeds a*b.
- R5: With APPROX=1, p equals a*b whenever either operand is zero or has exactly one bit set.
- R6: With APPROX=1 at N=8, at least one operand pair gives p below a*b; the error distance is reported.
- R7: The final prefix adder returns (x+y) mod 2^W, including a carry that travels across every bit position.
- R8: With OUT_REG=1, p changes only at a rising clock edge. After the edge it holds the product of the operands present just before that edge.
- R9: With OUT_REG=1, rst high at a rising edge clears p to zero.
- R10: With OUT_REG=0, p follows the operands with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| p | output | 2N | Product, exact or approximate per APPROX |

## Verification
The exact 8-bit tree is swept over all 65536 pairs. A misplaced carry index or a dropped leftover bit in any column would show up there as a wrong product. The same sweep on the approximate tree looks for any product above the true value, which a compressor that overcounts or a wrong final adder would cause. It also requires exactness for zero and one-hot operands, and at least some undercount; a tree that silently fell back to exact cells would fail that last check. The compressor is driven through all sixteen patterns, including its two deliberate misses. The prefix adder is hit with all-ones plus one and alternating patterns, which a missing prefix level would corrupt. The registered output is checked for one-cycle latency, for holding between edges, and for clearing on reset.

// File: rtl/cmptree_pkg.sv
package cmptree_pkg;

    localparam int MAX_COLS = 257;

    typedef struct packed {
        logic cy;
        logic sm;
    } cs_t;

    function automatic cs_t full_add(input logic x, input logic y, input logic z);
        cs_t r;
        r.sm = x ^ y ^ z;
        r.cy = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    // bits that stay in a column after one stage
    function automatic int kept_bits(input int h, input bit apx);
        if (h <= 2) return h;
        if (apx) return (h / 4) + (((h % 4) == 3) ? 1 : (h % 4));
        return (h / 3) + (h % 3);
    endfunction

    // bits a column sends one weight up after one stage
    function automatic int carry_bits(input int h, input bit apx);
        if (h <= 2) return 0;
        if (apx) return (h / 4) + (((h % 4) == 3) ? 1 : 0);
        return h / 3;
    endfunction

    function automatic int col_height(input int n, input bit apx, input int stage, input int col);
        int h [MAX_COLS];
        int t [MAX_COLS];
        int cols;
        cols = 2 * n;
        for (int k = 0; k <= cols; k++)
            h[k] = (k < cols) ? ((k < n) ? k + 1 : cols - 1 - k) : 0;
        for (int s = 0; s < stage; s++) begin
            t[0] = kept_bits(h[0], apx);
            for (int k = 1; k < cols; k++)
                t[k] = kept_bits(h[k], apx) + carry_bits(h[k-1], apx);
            t[cols] = carry_bits(h[cols-1], apx);
            for (int k = 0; k <= cols; k++) h[k] = t[k];
        end
        return h[col];
    endfunction

    function automatic int stage_count(input int n, input bit apx);
        for (int s = 0; s < 4 * n; s++) begin
            bit done;
            done = 1'b1;
            for (int k = 0; k < 2 * n; k++)
                if (col_height(n, apx, s, k) > 2) done = 1'b0;
            if (done) return s;
        end
        return 4 * n;
    endfunction

    function automatic int max_height(input int n, input bit apx);
        int m;
        int ns;
        m = 1;
        ns = stage_count(n, apx);
        for (int s = 0; s <= ns; s++)
            for (int k = 0; k <= 2 * n; k++)
                if (col_height(n, apx, s, k) > m) m = col_height(n, apx, s, k);
        return m;
    endfunction

endpackage

// File: rtl/cmptree_cmp42.sv
module cmptree_cmp42 (
    input  logic [3:0] x,
    output logic       sm,
    output logic       cy
);
    always_comb begin
        // every pair except the outer pair sets the carry
        cy = (x[0] & x[1]) | (x[2] & x[3]) | (x[0] & x[2]) | (x[1] & x[2]) | (x[1] & x[3]);
        sm = (^x) | (x[0] & x[3] & (x[1] ~^ x[2]));
        if (!$isunknown(x)) begin
            // R3
            cmp_weight_chk: assert ({1'b0, cy, sm} ==
                ((x == 4'hF) ? 3'd3 : (x == 4'h9) ? 3'd1 : 3'($countones(x))));
        end
    end
endmodule

// File: rtl/cmptree_reduce.sv
module cmptree_reduce
    import cmptree_pkg::*;
#(
    parameter int N      = 16,
    parameter bit APPROX = 1'b1
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] row_a,
    output logic [2*N-1:0] row_b
);
    localparam int COLS = 2 * N;
    localparam int NSTG = stage_count(N, APPROX);
    localparam int HMAX = max_height(N, APPROX);
    localparam int GS   = APPROX ? 4 : 3;

    logic hp [NSTG+1][COLS+1][HMAX];

    // R1: partial products sorted into columns by weight
    for (genvar c = 0; c < COLS; c++) begin : g_pp
        localparam int ILO = (c > N - 1) ? c - N + 1 : 0;
        localparam int IHI = (c < N) ? c : N - 1;
        for (genvar i = ILO; i <= IHI; i++) begin : g_bit
            assign hp[0][c][i-ILO] = a[i] & b[c-i];
        end
    end

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int H  = col_height(N, APPROX, s, c);
            localparam int HN = (c + 1 < COLS) ? kept_bits(col_height(N, APPROX, s, c + 1), APPROX) : 0;
            localparam int Q  = (H > 2) ? H / GS : 0;
            localparam int R  = H - Q * GS;

            for (genvar g = 0; g < Q; g++) begin : g_grp
                if (APPROX) begin : g_c42
                    cmptree_cmp42 u_cmp (
                        .x  ({hp[s][c][4*g+3], hp[s][c][4*g+2], hp[s][c][4*g+1], hp[s][c][4*g]}),
                        .sm (hp[s+1][c][g]),
                        .cy (hp[s+1][c+1][HN+g])
                    );
                end else begin : g_fa
                    assign {hp[s+1][c+1][HN+g], hp[s+1][c][g]} =
                        full_add(hp[s][c][3*g], hp[s][c][3*g+1], hp[s][c][3*g+2]);
                end
            end

            if (APPROX && (R == 3)) begin : g_tail_fa
                assign {hp[s+1][c+1][HN+Q], hp[s+1][c][Q]} =
                    full_add(hp[s][c][GS*Q], hp[s][c][GS*Q+1], hp[s][c][GS*Q+2]);
            end else begin : g_tail_pass
                for (genvar k = 0; k < R; k++) begin : g_pass
                    assign hp[s+1][c][Q+k] = hp[s][c][GS*Q+k];
                end
            end
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_rows
        localparam int HF = col_height(N, APPROX, NSTG, c);
        if (HF > 0) begin : g_ra
            assign row_a[c] = hp[NSTG][c][0];
        end else begin : g_ra0
            assign row_a[c] = 1'b0;
        end
        if (HF > 1) begin : g_rb
            assign row_b[c] = hp[NSTG][c][1];
        end else begin : g_rb0
            assign row_b[c] = 1'b0;
        end
    end
endmodule

// File: rtl/cmptree_ksadd.sv
module cmptree_ksadd #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    // only the low W-1 positions can feed a carry inside the result
    localparam int M = W - 1;
    localparam int L = $clog2(M);

    logic gb [L+1][M];
    logic pb [L][M];

    for (genvar i = 0; i < M; i++) begin : g_pre
        assign gb[0][i] = x[i] & y[i];
        assign pb[0][i] = x[i] ^ y[i];
    end

    for (genvar l = 0; l < L; l++) begin : g_lvl
        localparam int D = 1 << l;
        for (genvar i = 0; i < M; i++) begin : g_node
            if (i >= D) begin : g_black
                assign gb[l+1][i] = gb[l][i] | (pb[l][i] & gb[l][i-D]);
                if (l + 1 < L) begin : g_p
                    assign pb[l+1][i] = pb[l][i] & pb[l][i-D];
                end
            end else begin : g_wire
                assign gb[l+1][i] = gb[l][i];
                if (l + 1 < L) begin : g_p
                    assign pb[l+1][i] = pb[l][i];
                end
            end
        end
    end

    assign s[0] = x[0] ^ y[0];
    for (genvar i = 1; i < W; i++) begin : g_sum
        assign s[i] = x[i] ^ y[i] ^ gb[L][i-1];
    end
endmodule

// File: rtl/cmptree_mul.sv
module cmptree_mul
    import cmptree_pkg::*;
#(
    parameter int N       = 16,
    parameter bit APPROX  = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);
    localparam int PW = 2 * N;

    logic [PW-1:0] ra;
    logic [PW-1:0] rb;
    logic [PW-1:0] prod;

    cmptree_reduce #(.N(N), .APPROX(APPROX)) u_red (
        .a     (a),
        .b     (b),
        .row_a (ra),
        .row_b (rb)
    );

    cmptree_ksadd #(.W(PW)) u_add (
        .x (ra),
        .y (rb),
        .s (prod)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) p <= '0;
            else     p <= prod;
        end

        // R5
        onehot_exact_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && (($countones($past(a)) <= 1) || ($countones($past(b)) <= 1)))
            |-> (p == PW'($past(a)) * PW'($past(b))));

        // R8
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $stable(a) && $stable(b)) |=> $stable(p));

        if (APPROX) begin : g_apx_chk
            // R4
            approx_bound_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (p <= PW'($past(a)) * PW'($past(b))));
        end else begin : g_ex_chk
            // R2
            exact_prod_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (p == PW'($past(a)) * PW'($past(b))));
        end
    end else begin : g_comb
        assign p = prod;
    end
endmodule

// File: tb/cmptree_mul_test.sv
module cmptree_mul_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [15:0] a16 = 16'hFFFF;
    logic [15:0] b16 = 16'hFFFF;
    logic [31:0] p16;
    logic [7:0]  a8 = '0;
    logic [7:0]  b8 = '0;
    logic [15:0] pe8;
    logic [15:0] pa8;
    logic [3:0]  cx = '0;
    logic        csm;
    logic        ccy;
    logic [31:0] kx = '0;
    logic [31:0] ky = '0;
    logic [31:0] ks;
    logic [31:0] seed = 32'h1F2E3D4C;

    cmptree_mul #(.N(16), .APPROX(1'b1), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst), .a(a16), .b(b16), .p(p16));
    cmptree_mul #(.N(8), .APPROX(1'b0), .OUT_REG(1'b0)) u_ex8 (
        .clk(clk), .rst(rst), .a(a8), .b(b8), .p(pe8));
    cmptree_mul #(.N(8), .APPROX(1'b1), .OUT_REG(1'b0)) u_ap8 (
        .clk(clk), .rst(rst), .a(a8), .b(b8), .p(pa8));
    cmptree_cmp42 u_cmp (.x(cx), .sm(csm), .cy(ccy));
    cmptree_ksadd #(.W(32)) u_ks (.x(kx), .y(ky), .s(ks));

    function automatic logic [31:0] rnd(input logic [31:0] v);
        logic [31:0] r;
        r = v ^ (v << 13);
        r = r ^ (r >> 17);
        r = r ^ (r << 5);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(p16 == 32'h0, "R9 reset clears product", 64'(p16), 64'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_compressor;
        for (int v = 0; v < 16; v++) begin
            int e;
            cx = 4'(v);
            #1;
            e = (v == 15) ? 3 : (v == 9) ? 1 : $countones(4'(v));
            chk((2 * int'(ccy) + int'(csm)) == e, "R3 compressor weight",
                64'(2 * int'(ccy) + int'(csm)), 64'(e));
        end
        cx = 4'hF; #1;
        chk({ccy, csm} == 2'b11, "R3 pattern 1111", 64'({ccy, csm}), 64'h3);
        cx = 4'h9; #1;
        chk({ccy, csm} == 2'b01, "R3 pattern 1001", 64'({ccy, csm}), 64'h1);
    endtask

    task automatic t_prefix;
        logic [31:0] e;
        kx = 32'hFFFF_FFFF; ky = 32'h1; #1;
        chk(ks == 32'h0, "R7 full carry chain", 64'(ks), 64'h0);
        kx = 32'h7FFF_FFFF; ky = 32'h1; #1;
        chk(ks == 32'h8000_0000, "R7 carry into top bit", 64'(ks), 64'h8000_0000);
        kx = 32'hAAAA_AAAA; ky = 32'h5555_5555; #1;
        chk(ks == 32'hFFFF_FFFF, "R7 alternating", 64'(ks), 64'hFFFF_FFFF);
        for (int i = 0; i < 200; i++) begin
            seed = rnd(seed); kx = seed;
            seed = rnd(seed); ky = seed;
            #1;
            e = kx + ky;
            chk(ks == e, "R7 random sum", 64'(ks), 64'(e));
        end
    endtask

    task automatic t_sweep8;
        int inexact;
        int max_ed;
        longint sum_ed;
        inexact = 0; max_ed = 0; sum_ed = 0;
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                logic [15:0] e;
                a8 = 8'(i); b8 = 8'(j);
                #1;
                e = 16'(i * j);
                // R1 R2: exact tree against the true product
                chk(pe8 == e, "R2 exact product", 64'(pe8), 64'(e));
                // R4: approximate tree may only undercount
                chk(pa8 <= e, "R4 approximate not above exact", 64'(pa8), 64'(e));
                if (($countones(a8) <= 1) || ($countones(b8) <= 1))
                    chk(pa8 == e, "R5 zero or one-hot operand exact", 64'(pa8), 64'(e));
                if (pa8 != e) begin
                    inexact++;
                    sum_ed += longint'(e) - longint'(pa8);
                    if (int'(e) - int'(pa8) > max_ed) max_ed = int'(e) - int'(pa8);
                end
            end
        end
        $display("approximate 8-bit: %0d of 65536 pairs inexact, max error distance %0d, total error distance %0d",
                 inexact, max_ed, sum_ed);
        chk(inexact > 0, "R6 approximation present", 64'(inexact), 64'h1);
    endtask

    task automatic t_comb;
        @(posedge clk);
        #1;
        a8 = 8'hC3; b8 = 8'h5A;
        #1;
        chk(pe8 == 16'(8'hC3 * 8'h5A), "R10 combinational path", 64'(pe8), 64'(16'hC3 * 16'h5A));
    endtask

    task automatic t_reg16;
        logic [31:0] e;
        logic [31:0] prev;
        @(negedge clk);
        a16 = 16'h0040; b16 = 16'hBEEF;
        @(posedge clk); #1;
        e = 32'h0040 * 32'hBEEF;
        chk(p16 == e, "R8 one-cycle latency", 64'(p16), 64'(e));
        @(negedge clk);
        prev = p16;
        a16 = 16'h1234; b16 = 16'h8000;
        #1;
        chk(p16 == prev, "R8 holds between edges", 64'(p16), 64'(prev));
        @(posedge clk); #1;
        e = 32'h1234 * 32'h8000;
        chk(p16 == e, "R8 R5 next product", 64'(p16), 64'(e));
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            seed = rnd(seed);
            a16 = 16'(32'h1 << (seed[3:0]));
            b16 = seed[31:16];
            if (i[0]) begin
                b16 = a16; a16 = seed[31:16];
            end
            @(posedge clk); #1;
            e = 32'(a16) * 32'(b16);
            chk(p16 == e, "R5 one-hot 16-bit exact", 64'(p16), 64'(e));
        end
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            seed = rnd(seed);
            a16 = seed[15:0]; b16 = seed[31:16];
            if (i == 0) begin a16 = 16'hFFFF; b16 = 16'hFFFF; end
            @(posedge clk); #1;
            e = 32'(a16) * 32'(b16);
            chk(p16 <= e, "R4 16-bit not above exact", 64'(p16), 64'(e));
        end
    endtask

    task automatic t_midreset;
        @(negedge clk);
        a16 = 16'h7777; b16 = 16'h3333;
        rst = 1'b1;
        @(posedge clk); #1;
        chk(p16 == 32'h0, "R9 reset during operation", 64'(p16), 64'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(p16 <= 32'h7777 * 32'h3333, "R4 after reset", 64'(p16), 64'(32'h7777 * 32'h3333));
    endtask

    initial begin
        t_reset();
        t_compressor();
        t_prefix();
        t_comb();
        t_reg16();
        t_midreset();
        t_sweep8();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual 150000 cycles expected completion earlier");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule